// File: doc/BRIEF.md
# Dual-Edge Bidirectional Loadable Shift Register

This block is a W-bit shift register that changes state on both the rising and the falling edge of one clock, so it does two updates per clock period without a faster clock. On each edge it does one of four things: clear to zero, copy a parallel word, shift one place in a chosen direction, or hold. The choice follows a fixed priority: synchronous clear first, then parallel load, then the shift enable.

The register has one serial input for each direction. When it shifts toward the high end, bit 0 takes the left-feed input. When it shifts toward the low end, bit W-1 takes the right-feed input. An asynchronous power-on clear forces the whole register to zero at once, without waiting for an edge. The design is built from ordinary single-edge flip-flops. One register updates on the rising edge and one on the falling edge. The visible state is the XOR of the two registers, and each register stores the next state XORed with the other register's content.

Top module: `dual_edge_shreg`

## Requirements
- R1: The state updates on every rising edge and on every falling edge of `clk`. A shift moves the data one place per edge, so two places per clock period.
- R2: When `sync_clr`=1 at an edge, `q` becomes all zeros on that edge. This holds whatever the values of `load`, `shift_en`, `dir_up` and the data inputs.
- R3: When `sync_clr`=0 and `load`=1 at an edge, `q` takes `par_in`. This happens whether `shift_en` is 0 or 1.
- R4: When `sync_clr`, `load` and `shift_en` are all 0 at an edge, `q` keeps its value. Changes on `par_in`, `feed_lo` and `feed_hi` have no effect.
- R5: When `sync_clr`=0, `load`=0, `shift_en`=1 and `dir_up`=1 at an edge, `q[0]` takes `feed_lo` and each `q[n]` for n≥1 takes the old `q[n-1]`.
- R6: When `sync_clr`=0, `load`=0, `shift_en`=1 and `dir_up`=0 at an edge, `q[W-1]` takes `feed_hi` and each `q[n]` for n≤W-2 takes the old `q[n+1]`.
- R7: While `por`=1, `q` is all zeros at once, with no clock edge needed.
- R8: Each new state depends only on the state and inputs just before that edge. A sequence that changes mode or direction on consecutive edges of both polarities gives the same result as applying those steps one at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are active |
| por | input | 1 | Asynchronous power-on clear, active high |
| sync_clr | input | 1 | Synchronous clear, highest priority |
| load | input | 1 | Parallel load |
| shift_en | input | 1 | Shift enable |
| dir_up | input | 1 | 1: shift toward bit W-1; 0: shift toward bit 0 |
| feed_lo | input | 1 | Serial input into bit 0 when dir_up=1 |
| feed_hi | input | 1 | Serial input into bit W-1 when dir_up=0 |
| par_in | input | W | Parallel data input |
| q | output | W | Register state |

## Verification
On every edge of both polarities, the assertions compare the new state with a snapshot of the inputs and state taken at the edge before. This covers the clear, load, hold and both shift relations, and also the zero state while the power-on clear is high. Only the bench's scenarios can show that a whole chain of mixed operations across alternating edges ends in the right word. The same holds for two other points: that a power-on clear in the middle of a period takes effect without an edge, and that load works with the enable low alongside a bench model that is independent of the design.

// File: rtl/dual_edge_shreg.sv
module dual_edge_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por,
  input  logic         sync_clr,
  input  logic         load,
  input  logic         shift_en,
  input  logic         dir_up,
  input  logic         feed_lo,
  input  logic         feed_hi,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q
);

  logic [W-1:0] rise_r, fall_r, nxt;

  assign q = rise_r ^ fall_r;

  always_comb begin
    if (sync_clr)      nxt = '0;
    else if (load)     nxt = par_in;
    else if (!shift_en) nxt = q;
    else if (dir_up)   nxt = {q[W-2:0], feed_lo};
    else               nxt = {feed_hi, q[W-1:1]};
  end

  always_ff @(posedge clk or posedge por)
    if (por) rise_r <= '0;
    else     rise_r <= nxt ^ fall_r;

  always_ff @(negedge clk or posedge por)
    if (por) fall_r <= '0;
    else     fall_r <= nxt ^ rise_r;

  // Edge snapshots for the checks: controls {clr,load,en,dir,lo,hi}
  logic         pv, nv;
  logic [5:0]   pc, nc;
  logic [W-1:0] pd, nd, pq, nq;

  always_ff @(posedge clk or posedge por)
    if (por) begin pv <= 1'b0; pc <= '0; pd <= '0; pq <= '0; end
    else begin
      pv <= 1'b1; pc <= {sync_clr, load, shift_en, dir_up, feed_lo, feed_hi};
      pd <= par_in; pq <= q;
    end

  always_ff @(negedge clk or posedge por)
    if (por) begin nv <= 1'b0; nc <= '0; nd <= '0; nq <= '0; end
    else begin
      nv <= 1'b1; nc <= {sync_clr, load, shift_en, dir_up, feed_lo, feed_hi};
      nd <= par_in; nq <= q;
    end

  p_por_zero_r7: assert property (@(posedge clk) por |-> q == '0);

  p_clr_rise_r2: assert property (@(negedge clk) disable iff (por)
    (pv && pc[5]) |-> q == '0);
  p_clr_fall_r2: assert property (@(posedge clk) disable iff (por)
    (nv && nc[5]) |-> q == '0);
  p_load_rise_r3: assert property (@(negedge clk) disable iff (por)
    (pv && pc[5:4] == 2'b01) |-> q == pd);
  p_load_fall_r3: assert property (@(posedge clk) disable iff (por)
    (nv && nc[5:4] == 2'b01) |-> q == nd);
  p_hold_rise_r4: assert property (@(negedge clk) disable iff (por)
    (pv && pc[5:3] == 3'b000) |-> q == pq);
  p_hold_fall_r4: assert property (@(posedge clk) disable iff (por)
    (nv && nc[5:3] == 3'b000) |-> q == nq);
  p_up_rise_r5: assert property (@(negedge clk) disable iff (por)
    (pv && pc[5:2] == 4'b0011) |-> q == {pq[W-2:0], pc[1]});
  p_up_fall_r5: assert property (@(posedge clk) disable iff (por)
    (nv && nc[5:2] == 4'b0011) |-> q == {nq[W-2:0], nc[1]});
  p_dn_rise_r6: assert property (@(negedge clk) disable iff (por)
    (pv && pc[5:2] == 4'b0010) |-> q == {pc[0], pq[W-1:1]});
  p_dn_fall_r6: assert property (@(posedge clk) disable iff (por)
    (nv && nc[5:2] == 4'b0010) |-> q == {nc[0], nq[W-1:1]});

endmodule

// File: tb/dual_edge_shreg_tb.sv
module dual_edge_shreg_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, por = 1'b1;
  logic sync_clr = 0, load = 0, shift_en = 0, dir_up = 0, feed_lo = 0, feed_hi = 0;
  logic [W-1:0] par_in = '0, q, model = '0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  dual_edge_shreg #(.W(W)) u_dut (
    .clk(clk), .por(por), .sync_clr(sync_clr), .load(load), .shift_en(shift_en),
    .dir_up(dir_up), .feed_lo(feed_lo), .feed_hi(feed_hi), .par_in(par_in), .q(q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] s, input logic r, l, e, d,
                                            input logic lo, hi, input logic [W-1:0] di);
    if (r) return '0;
    if (l) return di;
    if (!e) return s;
    if (d) return {s[W-2:0], lo};
    return {hi, s[W-1:1]};
  endfunction

  // One active edge (alternates polarity), then check 1 ns after it
  task automatic step(input logic r, l, e, d, lo, hi, input logic [W-1:0] di, input string req);
    sync_clr = r; load = l; shift_en = e; dir_up = d; feed_lo = lo; feed_hi = hi; par_in = di;
    @(clk); #1;
    model = ref_next(model, r, l, e, d, lo, hi, di);
    chk(req, q, model);
  endtask

  task automatic t_load;
    step(0, 1, 0, 0, 1, 1, 8'hA5, "R3 load with enable low");
    step(0, 1, 1, 1, 0, 0, 8'h3C, "R3 load with enable high");
    chk("R3 value", q, 8'h3C);
  endtask

  task automatic t_hold;
    step(0, 1, 0, 0, 0, 0, 8'h96, "R3 preload");
    step(0, 0, 0, 1, 1, 1, 8'hFF, "R4 hold rise/fall 1");
    step(0, 0, 0, 0, 1, 0, 8'h00, "R4 hold rise/fall 2");
    step(0, 0, 0, 1, 0, 1, 8'h5A, "R4 hold rise/fall 3");
    chk("R4 unchanged", q, 8'h96);
  endtask

  task automatic t_clear;
    step(0, 1, 0, 0, 0, 0, 8'hE7, "R3 preload");
    step(1, 1, 1, 1, 1, 1, 8'hFF, "R2 clear over load and shift");
    chk("R2 zero", q, '0);
    step(0, 1, 0, 0, 0, 0, 8'h81, "R3 preload");
    step(1, 0, 1, 0, 1, 1, 8'h00, "R2 clear over shift");
  endtask

  task automatic t_shift_up;
    step(0, 1, 0, 0, 0, 0, 8'h81, "R3 preload");
    step(0, 0, 1, 1, 1, 0, 8'h00, "R5 up edge A");
    step(0, 0, 1, 1, 0, 1, 8'h00, "R5 up edge B");
    step(0, 0, 1, 1, 1, 0, 8'h00, "R5 up edge C");
    step(0, 0, 1, 1, 1, 0, 8'h00, "R1 up edge D");
    chk("R1 four places in two periods", q, 8'h1B);
  endtask

  task automatic t_shift_dn;
    step(0, 1, 0, 0, 0, 0, 8'h81, "R3 preload");
    step(0, 0, 1, 0, 0, 1, 8'h00, "R6 down edge A");
    step(0, 0, 1, 0, 1, 0, 8'h00, "R6 down edge B");
    step(0, 0, 1, 0, 0, 1, 8'h00, "R6 down edge C");
    chk("R6 value", q, 8'hB0);
  endtask

  task automatic t_mixed;
    step(0, 1, 0, 0, 0, 0, 8'h0F, "R3 preload");
    for (int i = 0; i < 12; i++)
      step(0, (i == 7), 1, i[0], i[1], i[2], 8'hC3, "R8 alternating mix");
  endtask

  task automatic t_por;
    step(0, 1, 0, 0, 0, 0, 8'hFF, "R3 preload");
    por = 1; #1;
    chk("R7 async clear without edge", q, '0);
    por = 0; model = '0; #1;
    step(0, 0, 0, 0, 0, 0, 8'h00, "R7 stays clear");
  endtask

  initial begin
    #3;
    chk("R7 reset state", q, '0);
    por = 0;
    t_load; t_hold; t_clear; t_shift_up; t_shift_dn; t_mixed; t_por;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: q=%h expected completion", q);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule